// File: doc/BRIEF.md
# Near Branch Target Resolver

This unit works out the new instruction pointer for an intra-segment jump, either a short or near relative jump or an absolute near jump whose target has already been fetched. A relative request adds a sign-extended displacement to the address of the instruction after the jump. An absolute request takes a supplied target value as it is. The result is then cut down to the active operand size. After that the unit checks whether the target is legal. Outside 64-bit mode this is a test against the code-segment limit. In 64-bit mode it is a test that the address is canonical.

The request is presented for one cycle with `reqValid`. On the next clock edge the unit does one of two things. If the target is legal, it loads the pointer register and pulses `commit`. If not, it leaves the pointer untouched and pulses `gpFault`, which stands for a general-protection fault with error code zero. The code-segment selector is not part of the result, because near jumps never change it. Decode, operand fetch and segment base addition happen elsewhere.

Top module: `near_target_unit`

## Requirements
- R1: While `rstN` is low and after its release, `curPtr` equals the parameter `RESET_PTR` (default 0x000000000000FFF0), and `commit` and `gpFault` are 0.
- R2: With `isRelative`=1, the raw target is `nextPtr` plus `disp` sign-extended to 64 bits from 8 bits (`dispWidth`=0), 16 bits (1) or 32 bits (2 or 3). Additions wrap modulo 2^64.
- R3: With `isRelative`=0, the raw target is `absTarget`, and `disp` and `dispWidth` have no effect on the result.
- R4: `opSize` 0 (16-bit) clears bits 63:16 of the raw target, 1 (32-bit) clears bits 63:32, and 2 or 3 (64-bit) keeps all 64 bits. Both the limit and canonical checks apply to this masked value.
- R5: With `longMode`=0, a masked target greater than `csLimit` (unsigned, zero-extended) is a fault. A target equal to the limit is legal.
- R6: With `longMode`=1, a masked target whose bits 63:47 are not all equal is a fault, and `csLimit` is ignored.
- R7: With `longMode`=1, a relative request with `dispWidth`=1 is a fault whatever its target.
- R8: On a fault, `gpFault` is 1 for exactly the one cycle after the request, `commit` stays 0, and `curPtr` keeps its value.
- R9: A legal request loads `curPtr` with the masked target and sets `commit` for the cycle after the request. With no request both strobes are 0 and `curPtr` holds. `commit` and `gpFault` are never 1 together. Back-to-back requests are each resolved in turn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, one cycle per jump |
| isRelative | input | 1 | 1: relative displacement, 0: absolute target |
| nextPtr | input | 64 | Address of the instruction after the jump |
| disp | input | 32 | Displacement, low bits used per width code |
| dispWidth | input | 2 | Displacement width: 0=8, 1=16, 2/3=32 bits |
| absTarget | input | 64 | Absolute target value |
| opSize | input | 2 | Operand size: 0=16, 1=32, 2/3=64 bits |
| longMode | input | 1 | 1 when executing in 64-bit mode |
| csLimit | input | 32 | Code-segment limit |
| curPtr | output | 64 | Current instruction pointer |
| commit | output | 1 | Pulse: pointer loaded with a new target |
| gpFault | output | 1 | Pulse: target rejected, error code zero |

## Verification
Relative jumps are tried with all three displacement widths and with negative values at the width extremes. This shows whether the sign extension comes from the right bit. Wrapping sums under 16-bit and 32-bit operand sizes show whether the mask is applied before the checks. Targets exactly at the limit, one above it, and on either side of the canonical boundary separate an off-by-one compare from a correct one, and show whether the check follows `longMode`. Random requests, some back to back and some with idle gaps, mix modes, sizes and absolute targets with random displacements. These show that a fault never moves the pointer and that an absolute target ignores the displacement.

// File: rtl/near_target_pkg.sv
package near_target_pkg;

  typedef enum logic [1:0] {
    DW_8  = 2'd0,
    DW_16 = 2'd1,
    DW_32 = 2'd2,
    DW_32X = 2'd3
  } dispWidth_e;

  typedef enum logic [1:0] {
    OS_16 = 2'd0,
    OS_32 = 2'd1,
    OS_64 = 2'd2,
    OS_64X = 2'd3
  } opSize_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadPtr;
    logic useRelative;
  } ntStrobes_t;

endpackage

// File: rtl/nt_datapath.sv
module nt_datapath
  import near_target_pkg::*;
#(
  parameter int PTR_W = 64,
  parameter int DISP_W = 32,
  parameter int VA_W = 48,
  parameter int LIM_W = 32,
  parameter logic [PTR_W-1:0] RESET_PTR = 64'h0000_0000_0000_FFF0
) (
  input  logic             clk,
  input  logic             rstN,
  input  ntStrobes_t       strobes,
  input  logic [PTR_W-1:0] nextPtr,
  input  logic [DISP_W-1:0] disp,
  input  logic [1:0]       dispWidth,
  input  logic [PTR_W-1:0] absTarget,
  input  logic [1:0]       opSize,
  input  logic [LIM_W-1:0] csLimit,
  output logic [PTR_W-1:0] curPtr,
  output logic             canonOk,
  output logic             limitOk
);
  localparam int HI_BITS = PTR_W - VA_W + 1;

  logic [PTR_W-1:0] dispExt;
  logic [PTR_W-1:0] rawTarget;
  logic [PTR_W-1:0] maskedTarget;
  logic [HI_BITS-1:0] topBits;

  always_comb begin
    unique case (dispWidth_e'(dispWidth))
      DW_8:    dispExt = {{(PTR_W-8){disp[7]}}, disp[7:0]};
      DW_16:   dispExt = {{(PTR_W-16){disp[15]}}, disp[15:0]};
      default: dispExt = {{(PTR_W-DISP_W){disp[DISP_W-1]}}, disp};
    endcase
  end

  always_comb begin
    if (strobes.useRelative) rawTarget = nextPtr + dispExt;
    else                     rawTarget = absTarget;
  end

  always_comb begin
    unique case (opSize_e'(opSize))
      OS_16:   maskedTarget = {{(PTR_W-16){1'b0}}, rawTarget[15:0]};
      OS_32:   maskedTarget = {{(PTR_W-32){1'b0}}, rawTarget[31:0]};
      default: maskedTarget = rawTarget;
    endcase
  end

  assign topBits = maskedTarget[PTR_W-1:VA_W-1];
  assign canonOk = (&topBits) | ~(|topBits);
  assign limitOk = !(maskedTarget > {{(PTR_W-LIM_W){1'b0}}, csLimit});

  always_ff @(posedge clk) begin
    if (!rstN)                curPtr <= RESET_PTR;
    else if (strobes.loadPtr) curPtr <= maskedTarget;
  end

endmodule

// File: rtl/nt_control.sv
module nt_control
  import near_target_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       isRelative,
  input  logic [1:0] dispWidth,
  input  logic       longMode,
  input  logic       canonOk,
  input  logic       limitOk,
  output ntStrobes_t strobes,
  output logic       commit,
  output logic       gpFault
);
  logic badWidth;
  logic badTarget;
  logic faultNow;

  assign badWidth  = longMode && isRelative && (dispWidth_e'(dispWidth) == DW_16);
  assign badTarget = longMode ? !canonOk : !limitOk;
  assign faultNow  = reqValid && (badWidth || badTarget);

  always_comb begin
    strobes.useRelative = isRelative;
    strobes.loadPtr     = reqValid && !faultNow;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      commit  <= 1'b0;
      gpFault <= 1'b0;
    end else begin
      commit  <= strobes.loadPtr;
      gpFault <= faultNow;
    end
  end

endmodule

// File: rtl/near_target_unit.sv
module near_target_unit
  import near_target_pkg::*;
#(
  parameter int PTR_W = 64,
  parameter int DISP_W = 32,
  parameter int VA_W = 48,
  parameter int LIM_W = 32,
  parameter logic [PTR_W-1:0] RESET_PTR = 64'h0000_0000_0000_FFF0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              isRelative,
  input  logic [PTR_W-1:0]  nextPtr,
  input  logic [DISP_W-1:0] disp,
  input  logic [1:0]        dispWidth,
  input  logic [PTR_W-1:0]  absTarget,
  input  logic [1:0]        opSize,
  input  logic              longMode,
  input  logic [LIM_W-1:0]  csLimit,
  output logic [PTR_W-1:0]  curPtr,
  output logic              commit,
  output logic              gpFault
);
  ntStrobes_t strobes;
  logic canonOk;
  logic limitOk;

  nt_control u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .isRelative(isRelative),
    .dispWidth(dispWidth), .longMode(longMode), .canonOk(canonOk),
    .limitOk(limitOk), .strobes(strobes), .commit(commit), .gpFault(gpFault)
  );

  nt_datapath #(
    .PTR_W(PTR_W), .DISP_W(DISP_W), .VA_W(VA_W), .LIM_W(LIM_W), .RESET_PTR(RESET_PTR)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .nextPtr(nextPtr), .disp(disp),
    .dispWidth(dispWidth), .absTarget(absTarget), .opSize(opSize),
    .csLimit(csLimit), .curPtr(curPtr), .canonOk(canonOk), .limitOk(limitOk)
  );

endmodule

// File: rtl/near_target_unit_chk.sv
module near_target_unit_chk #(
  parameter int PTR_W = 64,
  parameter int VA_W = 48,
  parameter int LIM_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic             isRelative,
  input logic [1:0]       dispWidth,
  input logic [1:0]       opSize,
  input logic             longMode,
  input logic [LIM_W-1:0] csLimit,
  input logic [PTR_W-1:0] curPtr,
  input logic             commit,
  input logic             gpFault
);
  logic [PTR_W-VA_W:0] hiBits;
  assign hiBits = curPtr[PTR_W-1:VA_W-1];

  assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(commit && gpFault));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (!commit && !gpFault));

  assert_req_answered_R9: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> (commit || gpFault));

  assert_ptr_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !commit |-> $stable(curPtr));

  assert_canon_commit_R6: assert property (@(posedge clk) disable iff (!rstN)
    (commit && $past(longMode)) |-> ((&hiBits) || !(|hiBits)));

  assert_limit_commit_R5: assert property (@(posedge clk) disable iff (!rstN)
    (commit && !$past(longMode)) |-> (curPtr <= {{(PTR_W-LIM_W){1'b0}}, $past(csLimit)}));

  assert_rel16_fault_R7: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && longMode && isRelative && dispWidth == 2'd1) |=> gpFault);

  assert_size16_mask_R4: assert property (@(posedge clk) disable iff (!rstN)
    (commit && $past(opSize) == 2'd0) |-> (curPtr[PTR_W-1:16] == '0));

endmodule

bind near_target_unit near_target_unit_chk #(.PTR_W(PTR_W), .VA_W(VA_W), .LIM_W(LIM_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .isRelative(isRelative),
  .dispWidth(dispWidth), .opSize(opSize), .longMode(longMode), .csLimit(csLimit),
  .curPtr(curPtr), .commit(commit), .gpFault(gpFault)
);

// File: tb/sim_near_target_unit.sv
`timescale 1ns/1ps
module sim_near_target_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        isRelative = 1'b0;
  logic [63:0] nextPtr = '0;
  logic [31:0] disp = '0;
  logic [1:0]  dispWidth = '0;
  logic [63:0] absTarget = '0;
  logic [1:0]  opSize = '0;
  logic        longMode = 1'b0;
  logic [31:0] csLimit = '0;
  logic [63:0] curPtr;
  logic        commit;
  logic        gpFault;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  logic [63:0] expPtr;

  always #2 clk = ~clk;

  near_target_unit u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .isRelative(isRelative),
    .nextPtr(nextPtr), .disp(disp), .dispWidth(dispWidth), .absTarget(absTarget),
    .opSize(opSize), .longMode(longMode), .csLimit(csLimit),
    .curPtr(curPtr), .commit(commit), .gpFault(gpFault)
  );

  function automatic logic [63:0] refTarget(bit rel, logic [63:0] np, logic [31:0] d,
                                            logic [1:0] w, logic [63:0] abst, logic [1:0] os);
    logic [63:0] ext, t;
    if (w == 2'd0)      ext = 64'($signed(d[7:0]));
    else if (w == 2'd1) ext = 64'($signed(d[15:0]));
    else                ext = 64'($signed(d));
    t = rel ? np + ext : abst;
    if (os == 2'd0)      t = t & 64'hFFFF;
    else if (os == 2'd1) t = t & 64'hFFFF_FFFF;
    return t;
  endfunction

  function automatic bit refFault(logic [63:0] t, bit lm, bit rel, logic [1:0] w, logic [31:0] lim);
    if (lm) begin
      if (rel && w == 2'd1) return 1'b1;
      return !(t[63:47] == 17'h0 || t[63:47] == 17'h1FFFF);
    end
    return t > {32'h0, lim};
  endfunction

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called at a negedge; drives one request, checks the cycle after it
  task automatic runReq(string tag, bit rel, logic [63:0] np, logic [31:0] d, logic [1:0] w,
                        logic [63:0] abst, logic [1:0] os, bit lm, logic [31:0] lim, bit idleAfter);
    logic [63:0] t;
    bit f;
    reqValid = 1'b1; isRelative = rel; nextPtr = np; disp = d; dispWidth = w;
    absTarget = abst; opSize = os; longMode = lm; csLimit = lim;
    t = refTarget(rel, np, d, w, abst, os);
    f = refFault(t, lm, rel, w, lim);
    @(posedge clk);
    @(negedge clk);
    if (!f) expPtr = t;
    check(gpFault == f, {tag, " fault flag"}, 64'(gpFault), 64'(f));
    check(commit == !f, {tag, " commit flag"}, 64'(commit), 64'(!f));
    check(curPtr == expPtr, {tag, " pointer"}, curPtr, expPtr);
    if (idleAfter) reqValid = 1'b0;
  endtask

  task automatic idleCycle();
    reqValid = 1'b0;
    disp = $urandom; absTarget = {$urandom, $urandom};
    @(posedge clk);
    @(negedge clk);
    check(!commit && !gpFault, "R9 idle strobes", {62'h0, commit, gpFault}, 64'h0);
    check(curPtr == expPtr, "R9 idle pointer", curPtr, expPtr);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%h expected=%h", 64'h1, 64'h0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    expPtr = 64'h0000_0000_0000_FFF0;
    repeat (3) @(negedge clk);
    check(curPtr == expPtr && !commit && !gpFault, "R1 in reset", curPtr, expPtr);
    rstN = 1'b1;
    @(negedge clk);
    check(curPtr == expPtr && !commit && !gpFault, "R1 after release", curPtr, expPtr);

    // directed corners
    runReq("R2 rel8 -128", 1, 64'h1000, 32'h0000_0080, 2'd0, 64'h0, 2'd1, 0, 32'hFFFF, 1);
    runReq("R5 rel16 at limit", 1, 64'h1_0001, 32'h0000_FFFE, 2'd1, 64'h0, 2'd0, 0, 32'hFFFF, 1);
    runReq("R5 R8 above limit", 1, 64'h1_0001, 32'h0000_FFFE, 2'd1, 64'h0, 2'd0, 0, 32'hFFFE, 1);
    idleCycle();
    runReq("R4 size16 wrap", 1, 64'hFFF0, 32'h20, 2'd0, 64'h0, 2'd0, 0, 32'hFFFF, 1);
    runReq("R4 size32 wrap", 1, 64'hFFFF_FFF0, 32'h20, 2'd2, 64'h0, 2'd1, 0, 32'hFFFF_FFFF, 1);
    runReq("R6 canon top low", 0, 64'h0, 32'h0, 2'd2, 64'h0000_7FFF_FFFF_FFFF, 2'd2, 1, 32'h0, 1);
    runReq("R6 R8 noncanon", 0, 64'h0, 32'h0, 2'd2, 64'h0000_8000_0000_0000, 2'd2, 1, 32'h0, 1);
    runReq("R6 canon bottom high", 0, 64'h0, 32'h0, 2'd2, 64'hFFFF_8000_0000_0000, 2'd2, 1, 32'h0, 1);
    runReq("R7 rel16 in long", 1, 64'h100, 32'h4, 2'd1, 64'h0, 2'd2, 1, 32'hFFFF_FFFF, 1);
    runReq("R6 limit ignored", 0, 64'h0, 32'h0, 2'd0, 64'h0000_0000_0040_0000, 2'd2, 1, 32'h0, 1);
    runReq("R3 disp ignored", 0, 64'hDEAD, 32'h7FFF_FFFF, 2'd2, 64'h1234, 2'd1, 0, 32'hFFFF, 1);
    runReq("R2 rel32 negative", 1, 64'h10, 32'hFFFF_FFF0, 2'd2, 64'h0, 2'd2, 1, 32'h0, 0);
    runReq("R9 back to back", 1, 64'h2000, 32'h7F, 2'd0, 64'h0, 2'd1, 0, 32'hFFFF, 1);
    idleCycle();

    // constrained random
    for (int i = 0; i < 400; i++) begin
      bit lm = $urandom_range(0, 1);
      bit rel = $urandom_range(0, 2) != 0;
      logic [1:0] os = lm ? (($urandom_range(0, 3) == 0) ? 2'($urandom_range(0, 1)) : 2'd2)
                          : 2'($urandom_range(0, 1));
      logic [63:0] np;
      logic [63:0] abst;
      logic [31:0] lim = ($urandom_range(0, 1) != 0) ? $urandom : 32'($urandom_range(0, 32'h2_0000));
      if (lm) begin
        case ($urandom_range(0, 2))
          0: np = 64'h0000_7FFF_FFFF_0000 + 64'($urandom_range(0, 32'h1_FFFF));
          1: np = 64'hFFFF_8000_0000_0000 - 64'($urandom_range(0, 32'h1_0000));
          default: np = {$urandom, $urandom};
        endcase
        abst = ($urandom_range(0, 1) != 0) ? {$urandom, $urandom} : np;
      end else begin
        np = {32'h0, 32'($urandom_range(0, 32'h3_0000))};
        abst = {$urandom, $urandom};
      end
      runReq(rel ? "R2 R4 R5 R6 random" : "R3 R4 R5 R6 random", rel, np, $urandom,
             2'($urandom_range(0, 3)), abst, os, lm, lim, $urandom_range(0, 1) != 0);
      if ($urandom_range(0, 4) == 0) idleCycle();
    end
    idleCycle();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule